// File: doc/BRIEF.md
# Linear CCD Readout Timing Sequencer

This block produces every digital clock and control level needed to operate a line sensor whose readout register is a two-phase shift register with a fixed number of stages (150 by default). A single start command begins one acquisition. The sequencer first counts out a programmable integration interval. It then runs the lateral exchange: the transfer gate first moves the preload packets into the photodiodes, and then the first phase pulls the remaining charge back into the register. Finally it clocks the register out one stage per step and marks each completed step with a pixel-valid pulse and its index.

The two register phases never overlap. Between the fall of one phase and the rise of the other there is a gap of a programmable number of system clocks, and a programmed value of zero is treated as one. The preload injection strobe is active during the first-phase part of every step, so a fresh packet enters stage 1 each time a signal packet leaves the last stage. A read-enable input can park the register. While it is low at a step boundary, the clocks stop with the data held in place. A new start command cannot trigger another lateral exchange until the full pass has been clocked out.

Top module: `ccd_line_seq`

## Requirements
- R1: After reset, `busy`, `pixValid`, `startRejected` and all four clock outputs (`phiL1`, `phiL2`, `phiLat`, `phiPre`) are low.
- R2: A `startPulse` sampled while idle latches `intLength` and `deadTime`. The integration interval then lasts `intLength` clocks, or one clock when `intLength` is 0, before `phiLat` rises.
- R3: `phiLat` stays high for 2*LAT_CYC clocks. For the first LAT_CYC of them `phiL1` is low, and for the last LAT_CYC `phiL1` is high. `phiL2` is low throughout.
- R4: Readout is NUM_STAGES steps. Each step is `phiL1` high for PHASE_CYC clocks, a gap, `phiL2` high for PHASE_CYC clocks, and a gap. With read-enable held high, `busy` lasts integration + 2*LAT_CYC + NUM_STAGES*(2*PHASE_CYC + 2*gap) clocks.
- R5: `phiL1` and `phiL2` are never high together. Each gap between them during readout is exactly max(`deadTime`,1) clocks.
- R6: `phiPre` is high only while `phiL1` is high during readout (never during the lateral exchange). Over one pass it is high for NUM_STAGES*PHASE_CYC clocks.
- R7: `pixValid` is a one-clock pulse in the last clock of each step. Over a pass, `pixIndex` runs 0 to NUM_STAGES-1 in ascending order, one pulse per step.
- R8: `readEn` is sampled at the end of the collect phase and at each step boundary. While it is low there, the sequencer holds with `phiL1`, `phiL2` and `phiPre` low, no `pixValid` pulses and `busy` high. Once it goes high, readout resumes at the next stage index with no stage lost.
- R9: A `startPulse` sampled while `busy` is high is ignored and gives a one-clock `startRejected` pulse on the following clock. In particular, no second lateral exchange starts before all NUM_STAGES steps are done.
- R10: `busy` is high in every state except idle, and all clock outputs are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start-of-acquisition command |
| intLength | input | 16 | Integration length in system clocks |
| deadTime | input | 4 | Gap between phase edges in system clocks (0 acts as 1) |
| readEn | input | 1 | Read enable; low parks the register at a step boundary |
| phiL1 | output | 1 | First longitudinal register phase |
| phiL2 | output | 1 | Second longitudinal register phase |
| phiLat | output | 1 | Lateral transfer gate |
| phiPre | output | 1 | Preload injection strobe |
| pixValid | output | 1 | One pulse per completed longitudinal step |
| pixIndex | output | 8 | Stage index of the step just completed |
| busy | output | 1 | High whenever the sequencer is not idle |
| startRejected | output | 1 | Pulse when a start command was ignored |

## Verification
The hardest situations to reach are a parked register and a start command arriving while it is parked. In both, the data must stay put and the new start must not trigger another lateral exchange. The bench holds `readEn` low through the whole lateral exchange, fires a start while the register waits, and only then releases `readEn`. It then confirms that exactly one exchange occurred and that all indices came out. A second scenario drops `readEn` part way through a pass, waits to see that the pulse count and the clocks freeze, and then checks that the pass completes with no stage index missing.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEGRATE,
    ST_LAT_INJECT,
    ST_LAT_COLLECT,
    ST_READOUT,
    ST_HOLD
  } seqState_t;

  // Sub-phase inside one longitudinal step
  typedef enum logic [1:0] {
    SP_L1,
    SP_GAP1,
    SP_L2,
    SP_GAP2
  } stepPhase_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadInt;    // load integration length, latch gap setting
    logic loadLat;    // load lateral sub-sequence length
    logic loadPhase;  // load phase-high length
    logic loadDead;   // load gap length
    logic decCnt;     // count down
    logic clrIdx;     // clear stage index
    logic incIdx;     // advance stage index
  } seqStrobe_t;

endpackage

// File: rtl/ccd_seq_dp.sv
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int NUM_STAGES = 150,
  parameter int INT_W      = 16,
  parameter int DEAD_W     = 4,
  parameter int LAT_CYC    = 4,
  parameter int PHASE_CYC  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strobe,
  input  logic [INT_W-1:0]              intLength,
  input  logic [DEAD_W-1:0]             deadTime,
  output logic                          cntZero,
  output logic                          lastStep,
  output logic [$clog2(NUM_STAGES)-1:0] stepIdx
);

  localparam int IDX_W = $clog2(NUM_STAGES);
  localparam int CNT_W = (INT_W > DEAD_W) ? INT_W : DEAD_W;

  logic [CNT_W-1:0]  cnt;
  logic [DEAD_W-1:0] deadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      deadQ <= DEAD_W'(1);
    end else begin
      if (strobe.loadInt) begin
        cnt   <= (intLength == '0) ? '0 : (CNT_W'(intLength) - CNT_W'(1));
        deadQ <= (deadTime == '0) ? DEAD_W'(1) : deadTime;
      end else if (strobe.loadLat) begin
        cnt <= CNT_W'(LAT_CYC - 1);
      end else if (strobe.loadPhase) begin
        cnt <= CNT_W'(PHASE_CYC - 1);
      end else if (strobe.loadDead) begin
        cnt <= CNT_W'(deadQ) - CNT_W'(1);
      end else if (strobe.decCnt) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strobe.clrIdx) begin
      stepIdx <= '0;
    end else if (strobe.incIdx) begin
      stepIdx <= stepIdx + IDX_W'(1);
    end
  end

  assign cntZero  = (cnt == '0);
  assign lastStep = (stepIdx == IDX_W'(NUM_STAGES - 1));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       readEn,
  input  logic       cntZero,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       phiL1,
  output logic       phiL2,
  output logic       phiLat,
  output logic       phiPre,
  output logic       pixValid,
  output logic       busy,
  output logic       startRejected
);

  seqState_t  state, stateNxt;
  stepPhase_t phase, phaseNxt;

  always_comb begin
    stateNxt = state;
    phaseNxt = phase;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.loadInt = 1'b1;
          stateNxt       = ST_INTEGRATE;
        end
      end
      ST_INTEGRATE: begin
        if (cntZero) begin
          strobe.loadLat = 1'b1;
          stateNxt       = ST_LAT_INJECT;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_LAT_INJECT: begin
        if (cntZero) begin
          strobe.loadLat = 1'b1;
          stateNxt       = ST_LAT_COLLECT;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_LAT_COLLECT: begin
        if (cntZero) begin
          strobe.clrIdx = 1'b1;
          if (readEn) begin
            strobe.loadPhase = 1'b1;
            phaseNxt         = SP_L1;
            stateNxt         = ST_READOUT;
          end else begin
            stateNxt = ST_HOLD;
          end
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_READOUT: begin
        if (!cntZero) begin
          strobe.decCnt = 1'b1;
        end else begin
          unique case (phase)
            SP_L1: begin
              strobe.loadDead = 1'b1;
              phaseNxt        = SP_GAP1;
            end
            SP_GAP1: begin
              strobe.loadPhase = 1'b1;
              phaseNxt         = SP_L2;
            end
            SP_L2: begin
              strobe.loadDead = 1'b1;
              phaseNxt        = SP_GAP2;
            end
            SP_GAP2: begin
              strobe.incIdx = 1'b1;
              if (lastStep) begin
                stateNxt = ST_IDLE;
              end else if (readEn) begin
                strobe.loadPhase = 1'b1;
                phaseNxt         = SP_L1;
              end else begin
                stateNxt = ST_HOLD;
              end
            end
            default: phaseNxt = SP_L1;
          endcase
        end
      end
      ST_HOLD: begin
        if (readEn) begin
          strobe.loadPhase = 1'b1;
          phaseNxt         = SP_L1;
          stateNxt         = ST_READOUT;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      phase         <= SP_L1;
      startRejected <= 1'b0;
    end else begin
      state         <= stateNxt;
      phase         <= phaseNxt;
      startRejected <= startPulse && (state != ST_IDLE);
    end
  end

  logic inReadout;
  assign inReadout = (state == ST_READOUT);

  assign phiLat   = (state == ST_LAT_INJECT) || (state == ST_LAT_COLLECT);
  assign phiL1    = (state == ST_LAT_COLLECT) || (inReadout && phase == SP_L1);
  assign phiL2    = inReadout && (phase == SP_L2);
  assign phiPre   = inReadout && (phase == SP_L1);
  assign pixValid = inReadout && (phase == SP_GAP2) && cntZero;
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int NUM_STAGES = 150,
  parameter int INT_W      = 16,
  parameter int DEAD_W     = 4,
  parameter int LAT_CYC    = 4,
  parameter int PHASE_CYC  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startPulse,
  input  logic [INT_W-1:0]              intLength,
  input  logic [DEAD_W-1:0]             deadTime,
  input  logic                          readEn,
  output logic                          phiL1,
  output logic                          phiL2,
  output logic                          phiLat,
  output logic                          phiPre,
  output logic                          pixValid,
  output logic [$clog2(NUM_STAGES)-1:0] pixIndex,
  output logic                          busy,
  output logic                          startRejected
);

  seqStrobe_t strobe;
  logic       cntZero;
  logic       lastStep;

  ccd_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .readEn       (readEn),
    .cntZero      (cntZero),
    .lastStep     (lastStep),
    .strobe       (strobe),
    .phiL1        (phiL1),
    .phiL2        (phiL2),
    .phiLat       (phiLat),
    .phiPre       (phiPre),
    .pixValid     (pixValid),
    .busy         (busy),
    .startRejected(startRejected)
  );

  ccd_seq_dp #(
    .NUM_STAGES(NUM_STAGES),
    .INT_W     (INT_W),
    .DEAD_W    (DEAD_W),
    .LAT_CYC   (LAT_CYC),
    .PHASE_CYC (PHASE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .intLength(intLength),
    .deadTime (deadTime),
    .cntZero  (cntZero),
    .lastStep (lastStep),
    .stepIdx  (pixIndex)
  );

endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk #(
  parameter int NUM_STAGES = 150
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          startPulse,
  input logic                          phiL1,
  input logic                          phiL2,
  input logic                          phiLat,
  input logic                          phiPre,
  input logic                          pixValid,
  input logic [$clog2(NUM_STAGES)-1:0] pixIndex,
  input logic                          busy,
  input logic                          startRejected
);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(phiL1 && phiL2));

  assert_gap_before_l2_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phiL2) |-> $past(!phiL1));

  assert_gap_before_l1_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phiL1) && !phiLat) |-> $past(!phiL2));

  assert_l2_low_lateral_R3: assert property (@(posedge clk) disable iff (!rstN)
    phiLat |-> !phiL2);

  assert_inject_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phiL1) && phiLat) |-> $past(phiLat));

  assert_pre_in_l1_R6: assert property (@(posedge clk) disable iff (!rstN)
    phiPre |-> (phiL1 && !phiLat));

  assert_pix_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (busy && (32'(pixIndex) < NUM_STAGES)));

  assert_pix_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);

  assert_reject_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    startRejected |-> ($past(startPulse) && $past(busy)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(phiL1 || phiL2 || phiLat || phiPre || pixValid));

endmodule

bind ccd_line_seq ccd_line_seq_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startPulse   (startPulse),
  .phiL1        (phiL1),
  .phiL2        (phiL2),
  .phiLat       (phiLat),
  .phiPre       (phiPre),
  .pixValid     (pixValid),
  .pixIndex     (pixIndex),
  .busy         (busy),
  .startRejected(startRejected)
);

// File: tb/ccd_line_seq_tb.sv
module ccd_line_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSTG       = 150;
  localparam int LAT        = 4;
  localparam int PH         = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] intLength = '0;
  logic [3:0]  deadTime = '0;
  logic        readEn = 1'b1;
  logic        phiL1, phiL2, phiLat, phiPre, pixValid, busy, startRejected;
  logic [7:0]  pixIndex;

  ccd_line_seq u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .intLength(intLength),
    .deadTime(deadTime), .readEn(readEn), .phiL1(phiL1), .phiL2(phiL2),
    .phiLat(phiLat), .phiPre(phiPre), .pixValid(pixValid), .pixIndex(pixIndex),
    .busy(busy), .startRejected(startRejected)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // run statistics gathered at the falling edge
  int busyCyc, intCyc, latCyc, injCyc, l2Lat, overlap, preCyc, preBad;
  int pixCnt, idxErr, rejCnt, minGap, maxGap, gapRun;
  bit seenHigh;

  task automatic clearStats();
    busyCyc = 0; intCyc = 0; latCyc = 0; injCyc = 0; l2Lat = 0; overlap = 0;
    preCyc = 0; preBad = 0; pixCnt = 0; idxErr = 0; rejCnt = 0;
    minGap = 1000000; maxGap = 0; gapRun = 0; seenHigh = 1'b0;
  endtask

  initial clearStats();

  always @(negedge clk) begin
    if (busy) busyCyc++;
    if (busy && !phiLat && latCyc == 0) intCyc++;
    if (phiLat) latCyc++;
    if (phiLat && !phiL1) injCyc++;
    if (phiLat && phiL2) l2Lat++;
    if (phiL1 && phiL2) overlap++;
    if (phiPre) preCyc++;
    if (phiPre && (!phiL1 || phiLat)) preBad++;
    if (pixValid) begin
      if (int'(pixIndex) != pixCnt) idxErr++;
      pixCnt++;
    end
    if (startRejected) rejCnt++;
    if (phiL1 || phiL2) begin
      if (seenHigh && gapRun > 0) begin
        if (gapRun < minGap) minGap = gapRun;
        if (gapRun > maxGap) maxGap = gapRun;
      end
      gapRun = 0;
      seenHigh = 1'b1;
    end else if (seenHigh) begin
      gapRun++;
    end
  end

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      printSummary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic startRun(int nInt, int dead);
    @(negedge clk);
    intLength = 16'(nInt);
    deadTime  = 4'(dead);
    clearStats();
    pulseStart();
  endtask

  // R1: reset state
  task automatic testReset();
    rstN = 1'b0;
    waitCycles(3);
    check("R1 busy", int'(busy), 0);
    check("R1 clocks", int'({phiL1, phiL2, phiLat, phiPre}), 0);
    check("R1 pixValid/startRejected", int'({pixValid, startRejected}), 0);
    rstN = 1'b1;
    waitCycles(2);
  endtask

  // full pass with read-enable high
  task automatic testPass(int nInt, int dead, string tag);
    int effInt  = (nInt == 0) ? 1 : nInt;
    int effDead = (dead == 0) ? 1 : dead;
    readEn = 1'b1;
    startRun(nInt, dead);
    waitIdle();
    waitCycles(3);
    check({"R2 integration ", tag}, intCyc, effInt);
    check({"R3 lateral length ", tag}, latCyc, 2 * LAT);
    check({"R3 inject with L1 low ", tag}, injCyc, LAT);
    check({"R3 L2 during lateral ", tag}, l2Lat, 0);
    check({"R4 busy length ", tag}, busyCyc,
          effInt + 2 * LAT + NSTG * (2 * PH + 2 * effDead));
    check({"R5 overlap ", tag}, overlap, 0);
    check({"R5 min gap ", tag}, minGap, effDead);
    check({"R5 max gap ", tag}, maxGap, effDead);
    check({"R6 preload cycles ", tag}, preCyc, NSTG * PH);
    check({"R6 preload outside L1 ", tag}, preBad, 0);
    check({"R7 pixel count ", tag}, pixCnt, NSTG);
    check({"R7 index order ", tag}, idxErr, 0);
    check({"R10 idle clocks ", tag}, int'({busy, phiL1, phiL2, phiLat, phiPre}), 0);
  endtask

  // R9: start during an active pass
  task automatic testRejectRunning();
    readEn = 1'b1;
    startRun(20, 1);
    waitCycles(300);
    pulseStart();
    waitCycles(1);
    check("R9 reject pulse", rejCnt, 1);
    waitIdle();
    waitCycles(2);
    check("R9 busy not extended", busyCyc, 20 + 2 * LAT + NSTG * (2 * PH + 2));
    check("R9 single lateral", latCyc, 2 * LAT);
    check("R9 pixel count", pixCnt, NSTG);
  endtask

  // R8/R9: register parked after the lateral exchange, start while parked
  task automatic testHoldBeforeRead();
    readEn = 1'b0;
    startRun(10, 2);
    waitCycles(100);
    check("R8 held no pixels", pixCnt, 0);
    check("R8 held busy", int'(busy), 1);
    check("R8 held clocks low", int'({phiL1, phiL2, phiPre, phiLat}), 0);
    check("R8 lateral done once", latCyc, 2 * LAT);
    pulseStart();
    waitCycles(10);
    check("R9 reject while held", rejCnt, 1);
    check("R9 no second lateral", latCyc, 2 * LAT);
    @(negedge clk);
    readEn = 1'b1;
    waitIdle();
    waitCycles(2);
    check("R8 resumed pixel count", pixCnt, NSTG);
    check("R8 resumed index order", idxErr, 0);
    check("R9 lateral count at end", latCyc, 2 * LAT);
  endtask

  // R8: stall in the middle of readout
  task automatic testStallMid();
    int frozen;
    int preFrozen;
    readEn = 1'b1;
    startRun(5, 1);
    while (pixCnt < 40) @(negedge clk);
    readEn = 1'b0;
    waitCycles(20);
    frozen = pixCnt;
    preFrozen = preCyc;
    waitCycles(40);
    check("R8 stall pixel count", pixCnt, frozen);
    check("R8 stall preload frozen", preCyc, preFrozen);
    check("R8 stall clocks low", int'({phiL1, phiL2, phiPre}), 0);
    check("R8 stall busy", int'(busy), 1);
    @(negedge clk);
    readEn = 1'b1;
    waitIdle();
    waitCycles(2);
    check("R8 stall total pixels", pixCnt, NSTG);
    check("R8 stall index order", idxErr, 0);
  endtask

  initial begin
    testReset();
    testPass(20, 1, "base");
    testPass(0, 0, "zero");
    testPass(5, 3, "wide");
    testRejectRunning();
    testHoldBeforeRead();
    testStallMid();
    printSummary();
    $finish;
  end

endmodule